// File: doc/BRIEF.md
# Multi-Lane Serializer Transmit Framer

This block sits in front of a bank of serial line drivers. On every rising edge of the word clock it takes a 48-bit parallel word and splits it into eight lane frames. Each frame is seven slots long: six payload bits plus one balance bit, which a per-lane encoder picks to keep the line's running disparity near zero. Next to the data lanes it builds a seven-slot frame for a clock lane, which the far end uses to find frame boundaries. All frames are handed over as 7-bit parallel words at word rate. Slot 0 of each word is the slot sent first, and a downstream 7:1 shifter puts the slots on the wire.

A low level on the training request switches the block into a calibration mode. In that mode every data lane carries a fixed step pattern so that the receiver can place its sampling points. The clock lane switches to a second pattern that marks the mode. Input words are ignored and each lane's running disparity is frozen. The request is synchronized to the word clock. The switch happens only between whole frames, and one request always produces a minimum number of training frames. An active-low power-down input turns off the output enable and zeroes every slot.

Top module: `tfr_tx_framer`

## Requirements
- R1: Lane k (k = 0..7) takes input bits 6k to 6k+5 and carries them in slots 0 to 5 in that order, with slot 0 first. Slot 6 is the balance bit; when it is 1 the six payload slots are inverted. Lane k occupies tx_lanes[7k+6:7k], and slot i sits at bit 7k+i.
- R2: A word driven before rising edge n appears on tx_lanes just after rising edge n+1.
- R3: In data mode the clock lane carries send-order pattern 1111000 (tx_clk_lane = 7'b0001111) and pattern 1110000 (7'b0000111) on alternate frames. The first frame after reset uses the first of these, and the two then swap on every frame, whatever the mode.
- R4: For each lane, disparity d = (#ones − #zeros) of the six payload bits, and the running disparity rd starts at 0 after reset. The lane inverts when rd = 0, when rd > 0 and d > 0, or when rd < 0 and d ≤ 0; otherwise it sends the bits as they are. rd then changes by d − 1 (sent as is) or by 1 − d (inverted), and is clamped to the range −6..+7.
- R5: In a training frame the clock lane carries 1111100 (7'b0011111) on frames where the data-mode pattern would be 1111000, and 1100000 (7'b0000011) on the others. Every data lane carries that frame's data-mode clock pattern. Input words have no effect, and each lane's rd is held.
- R6: The training request is synchronized through two flops. When it is first sampled low at edge n, the first training frame appears just after edge n+3.
- R7: Once entered, training lasts at least 4 frames. A request that is low for one cycle gives exactly 4 training frames, and a request held low keeps training running.
- R8: If pd_n is sampled low at an edge, then after that edge tx_oe is 0 and every lane and clock-lane slot is 0. Frames lost this way do not advance rd. Output resumes at the first edge with pd_n high.
- R9: While rst_n is low at an edge, tx_oe and all output slots are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock; rising edge samples the input word |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 48 | Parallel input word |
| train_req_n | input | 1 | Active-low training request, asynchronous to the frame |
| pd_n | input | 1 | Active-low power-down |
| tx_lanes | output | 56 | Eight 7-slot lane words, lane k at bits 7k+6:7k |
| tx_clk_lane | output | 7 | Clock-lane slot pattern for this frame |
| tx_oe | output | 1 | Output enable for all lane drivers |

## Verification
If a lane's running disparity goes wrong, it shows up as a wrong balance bit and an inverted payload on that lane. This can take a few frames, because an error only becomes visible once it changes a later invert decision. The bench keeps its own disparity for each lane and compares every data frame. A wrong phase or mode state shows on the clock lane in the very frame where it happens. The bench counts training frames and the exact cycle at which training starts, so a wrong synchronizer depth or hold count shows up as a one-frame shift or an extra or missing frame.

// File: rtl/tfr_pkg.sv
// Shared constants for the transmit framer.
// Assumes seven slots per frame: six payload bits plus one balance bit.
package tfr_pkg;
    localparam int SLOTS = 7;
    localparam int DBITS = SLOTS - 1;
    localparam int RD_W  = 4;

    typedef logic [SLOTS-1:0] slot_word_t;

    // Slot 0 is at the LSB, so send order reads right to left.
    localparam slot_word_t PAT_DAT_A = 7'b0001111;  // 1111000
    localparam slot_word_t PAT_DAT_B = 7'b0000111;  // 1110000
    localparam slot_word_t PAT_TRN_A = 7'b0011111;  // 1111100
    localparam slot_word_t PAT_TRN_B = 7'b0000011;  // 1100000

    // Running disparity limits, given in the width of the intermediate sum.
    localparam logic signed [5:0] SUM_MAX = 6'sd7;
    localparam logic signed [5:0] SUM_MIN = -6'sd6;
endpackage

// File: rtl/tfr_lane_balancer.sv
// Per-lane balance encoder. It picks between sending the six payload bits
// as they are or inverted, based on a running disparity that is kept inside
// this block. The code word is combinational; the running disparity moves
// only when 'adv' says the code word is actually being sent.
module tfr_lane_balancer
    import tfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [DBITS-1:0] data,
    output slot_word_t       code
);
    logic signed [RD_W-1:0] rd_q;
    logic signed [RD_W-1:0] rd_d;
    logic [2:0]             ones;
    logic signed [5:0]      disp;
    logic signed [5:0]      rd_ext;
    logic signed [5:0]      delta;
    logic signed [5:0]      sum;
    logic                   invert;

    // Payload disparity, invert choice and clamped next running disparity.
    always_comb begin
        ones   = 3'($countones(data));
        disp   = $signed({2'b00, ones, 1'b0}) - 6'sd6;
        invert = (rd_q == 4'sd0) ||
                 ((rd_q > 4'sd0) && (disp > 6'sd0)) ||
                 ((rd_q < 4'sd0) && (disp <= 6'sd0));
        rd_ext = {{2{rd_q[RD_W-1]}}, rd_q};
        delta  = invert ? (6'sd1 - disp) : (disp - 6'sd1);
        sum    = rd_ext + delta;
        if (sum > SUM_MAX)      rd_d = 4'sd7;
        else if (sum < SUM_MIN) rd_d = -4'sd6;
        else                    rd_d = sum[RD_W-1:0];
        code = {invert, data ^ {DBITS{invert}}};
    end

    // Running disparity register; it is frozen in frames that are not sent.
    always_ff @(posedge clk) begin
        if (!rst_n)   rd_q <= '0;
        else if (adv) rd_q <= rd_d;
    end

    p_rd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q <= 4'sd7) && (rd_q >= -4'sd6));

    p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(rd_q));
endmodule

// File: rtl/tfr_mode_ctrl.sv
// Mode control: brings the training request into the clock domain, holds
// training for a minimum number of frames, and toggles the frame phase that
// selects between the two patterns of each pair. Assumes SYNC_STAGES >= 2
// and MIN_TRAIN >= 2.
module tfr_mode_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_TRAIN   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic train_req_n,
    output logic train_act,
    output logic phase
);
    localparam int CNT_W = $clog2(MIN_TRAIN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       hold_q;
    logic                   req;

    assign req = !sync_q[SYNC_STAGES-1];

    // Request synchronizer; resets to the idle (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], train_req_n};
    end

    // Enter on request, stay until the hold count is used up and the request is gone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            train_act <= 1'b0;
            hold_q    <= '0;
        end else if (!train_act) begin
            if (req) begin
                train_act <= 1'b1;
                hold_q    <= CNT_W'(MIN_TRAIN - 1);
            end
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end else if (!req) begin
            train_act <= 1'b0;
        end
    end

    // Frame phase toggles every frame in every mode.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= !phase;
    end

    p_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!train_act && req) |=> train_act);

    p_min_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (train_act && (hold_q != '0)) |=> train_act);

    p_phase_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase != $past(phase)));
endmodule

// File: rtl/tfr_tx_framer.sv
// Transmit framer top. It registers the input word, encodes each six-bit
// lane slice through its own balancer, and registers the lane words, the
// clock-lane pattern and the output enable. Latency from word to lanes is
// two edges. Training and power-down act on whole frames only.
module tfr_tx_framer
    import tfr_pkg::*;
#(
    parameter int LANES       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_TRAIN   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES*DBITS-1:0]   din,
    input  logic                     train_req_n,
    input  logic                     pd_n,
    output logic [LANES*SLOTS-1:0]   tx_lanes,
    output logic [SLOTS-1:0]         tx_clk_lane,
    output logic                     tx_oe
);
    localparam int WORD = LANES * DBITS;
    localparam int OUTW = LANES * SLOTS;

    logic [WORD-1:0] data_q;
    logic [OUTW-1:0] codes;
    logic            train_act;
    logic            phase;
    logic            enc_use;

    // Input word register; its content is used only in data frames.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= din;
    end

    tfr_mode_ctrl #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_TRAIN   (MIN_TRAIN)
    ) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .train_req_n (train_req_n),
        .train_act   (train_act),
        .phase       (phase)
    );

    assign enc_use = !train_act && pd_n;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tfr_lane_balancer u_bal (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (enc_use),
            .data  (data_q[k*DBITS +: DBITS]),
            .code  (codes[k*SLOTS +: SLOTS])
        );
    end

    // Output frame register: mode picks the patterns, power-down blanks everything.
    always_ff @(posedge clk) begin
        if (!rst_n || !pd_n) begin
            tx_lanes    <= '0;
            tx_clk_lane <= '0;
            tx_oe       <= 1'b0;
        end else begin
            tx_oe <= 1'b1;
            if (train_act) begin
                tx_clk_lane <= phase ? PAT_TRN_B : PAT_TRN_A;
                tx_lanes    <= {LANES{phase ? PAT_DAT_B : PAT_DAT_A}};
            end else begin
                tx_clk_lane <= phase ? PAT_DAT_B : PAT_DAT_A;
                tx_lanes    <= codes;
            end
        end
    end

    p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (!tx_oe && (tx_lanes == '0) && (tx_clk_lane == '0)));

    p_clk_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe |-> ((tx_clk_lane == PAT_DAT_A) || (tx_clk_lane == PAT_DAT_B) ||
                   (tx_clk_lane == PAT_TRN_A) || (tx_clk_lane == PAT_TRN_B)));

    p_train_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe && (tx_clk_lane == PAT_TRN_A)) |-> (tx_lanes == {LANES{PAT_DAT_A}}));

    p_train_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe && (tx_clk_lane == PAT_TRN_B)) |-> (tx_lanes == {LANES{PAT_DAT_B}}));
endmodule

// File: tb/sim_tfr_tx_framer.sv
// Directed bench for the transmit framer. Every cycle goes through 'step',
// which checks the frame on the outputs and then drives the next inputs.
module sim_tfr_tx_framer;
    localparam logic [6:0] E_DA = 7'b0001111;
    localparam logic [6:0] E_DB = 7'b0000111;
    localparam logic [6:0] E_TA = 7'b0011111;
    localparam logic [6:0] E_TB = 7'b0000011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] din = '0;
    logic        train_req_n = 1'b1;
    logic        pd_n = 1'b1;
    logic [55:0] tx_lanes;
    logic [6:0]  tx_clk_lane;
    logic        tx_oe;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    int          rd_m [8];
    logic [47:0] h0, h1;
    logic        ph;
    logic        trn_v = 1'b1;
    logic        pd_v = 1'b1;
    logic        last_train;
    logic [47:0] lfsr = 48'hA5C3_1F0E_9B27;

    always #2 clk = !clk;

    tfr_tx_framer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .din         (din),
        .train_req_n (train_req_n),
        .pd_n        (pd_n),
        .tx_lanes    (tx_lanes),
        .tx_clk_lane (tx_clk_lane),
        .tx_oe       (tx_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference lane encoder built from R1 and R4; it advances the model disparity.
    task automatic ref_enc(input logic [47:0] w, output logic [55:0] o);
        for (int k = 0; k < 8; k++) begin
            logic [5:0] d6;
            int dd;
            bit inv;
            d6  = w[6*k +: 6];
            dd  = 2 * $countones(d6) - 6;
            inv = (rd_m[k] == 0) || (rd_m[k] > 0 && dd > 0) || (rd_m[k] < 0 && dd <= 0);
            o[7*k +: 7] = {inv, inv ? ~d6 : d6};
            rd_m[k] += inv ? (1 - dd) : (dd - 1);
            if (rd_m[k] > 7)  rd_m[k] = 7;
            if (rd_m[k] < -6) rd_m[k] = -6;
        end
    endtask

    // One cycle: check the frame now on the outputs, then drive the next inputs.
    task automatic step(input logic [47:0] w);
        logic [55:0] e;
        bit tr;
        @(negedge clk);
        if (tx_oe) begin
            tr = (tx_clk_lane == E_TA) || (tx_clk_lane == E_TB);
            last_train = tr;
            if (tr) begin
                chk(tx_clk_lane == (ph ? E_TB : E_TA), "R5 training clock lane", 64'(tx_clk_lane), 64'(ph ? E_TB : E_TA));
                chk(tx_lanes == {8{ph ? E_DB : E_DA}}, "R5 training data lanes", 64'(tx_lanes), 64'({8{ph ? E_DB : E_DA}}));
            end else begin
                chk(tx_clk_lane == (ph ? E_DB : E_DA), "R3 data clock lane", 64'(tx_clk_lane), 64'(ph ? E_DB : E_DA));
                ref_enc(h1, e);
                chk(tx_lanes == e, "R1 R2 R4 lane words", 64'(tx_lanes), 64'(e));
            end
        end else begin
            last_train = 1'b0;
        end
        ph = !ph;
        din = w;
        train_req_n = trn_v;
        pd_n = pd_v;
        h1 = h0;
        h0 = w;
    endtask

    function automatic logic [47:0] next_rand(input logic [47:0] s);
        logic [47:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; din = '0; trn_v = 1'b1; pd_v = 1'b1;
        train_req_n = 1'b1; pd_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!tx_oe && tx_lanes == '0 && tx_clk_lane == '0, "R9 reset state", 64'({tx_oe, tx_clk_lane, tx_lanes}), 64'(0));
        rst_n = 1'b1;
        ph = 1'b0; h0 = '0; h1 = '0;
        for (int k = 0; k < 8; k++) rd_m[k] = 0;
    endtask

    // All-zero words: each lane alternates 1111111 and 0000000 (R4).
    task automatic t_zero_words();
        t_reset();
        step('0);
        chk(tx_lanes == {8{7'h7F}}, "R4 zero word first frame", 64'(tx_lanes), 64'({8{7'h7F}}));
        step('0);
        chk(tx_lanes == '0, "R4 zero word second frame", 64'(tx_lanes), 64'(0));
        step('0);
        chk(tx_lanes == {8{7'h7F}}, "R4 zero word third frame", 64'(tx_lanes), 64'({8{7'h7F}}));
    endtask

    task automatic t_patterns();
        t_reset();
        step(48'hFFFF_FFFF_FFFF);
        step(48'h5555_5555_5555);
        step(48'hAAAA_AAAA_AAAA);
        for (int i = 0; i < 48; i++) step(48'h1 << i);
        for (int i = 0; i < 8; i++) step(48'h3F << (6 * i));
        for (int i = 0; i < 64; i++) step(48'h0001_0203_0405 * 48'(i));
        step('0); step('0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 200; i++) begin
            lfsr = next_rand(lfsr);
            step(lfsr);
        end
        step('0); step('0);
    endtask

    // R6: exact entry latency; held request keeps training; data resumes with held rd (R5).
    task automatic t_train_latency();
        trn_v = 1'b0;
        step(48'h1234_5678_9ABC);
        step(48'hFFFF_0000_FFFF);
        step(48'h0F0F_0F0F_0F0F);
        step(48'h0000_0000_0001);
        chk(last_train == 1'b0, "R6 no training before third edge", 64'(last_train), 64'(0));
        step(48'h1111_1111_1111);
        chk(last_train == 1'b1, "R6 training starts after third edge", 64'(last_train), 64'(1));
        for (int i = 0; i < 10; i++) step(48'hDEAD_BEEF_0000 + 48'(i));
        chk(last_train == 1'b1, "R7 held request keeps training", 64'(last_train), 64'(1));
        trn_v = 1'b1;
        for (int i = 0; i < 10; i++) begin
            lfsr = next_rand(lfsr);
            step(lfsr);
        end
        chk(last_train == 1'b0, "R5 data mode resumes", 64'(last_train), 64'(0));
    endtask

    // R7: a one-cycle request gives exactly four training frames.
    task automatic t_train_pulse();
        int cnt;
        cnt = 0;
        trn_v = 1'b0;
        step(48'hCAFE_F00D_1234);
        trn_v = 1'b1;
        for (int i = 0; i < 12; i++) begin
            lfsr = next_rand(lfsr);
            step(lfsr);
            if (last_train) cnt++;
        end
        chk(cnt == 4, "R7 pulse gives minimum training", 64'(cnt), 64'(4));
    endtask

    // R8: power-down blanks outputs; rd is not advanced by lost frames.
    task automatic t_power_down();
        pd_v = 1'b0;
        step(48'h0123_4567_89AB);
        step(48'hFEDC_BA98_7654);
        chk(!tx_oe && tx_lanes == '0 && tx_clk_lane == '0, "R8 outputs off in power-down", 64'({tx_oe, tx_clk_lane, tx_lanes}), 64'(0));
        step(48'h0);
        pd_v = 1'b1;
        step(48'h0);
        chk(!tx_oe, "R8 still off while pd_n sampled low", 64'(tx_oe), 64'(0));
        step(48'h0F0F_F0F0_3C3C);
        chk(tx_oe, "R8 output resumes", 64'(tx_oe), 64'(1));
        for (int i = 0; i < 20; i++) begin
            lfsr = next_rand(lfsr);
            step(lfsr);
        end
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog expired");
        n_fail++;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_zero_words();
        t_patterns();
        t_random();
        t_train_latency();
        t_train_pulse();
        t_power_down();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule